// File: doc/BRIEF.md
# Stereo Clickless Attenuator with Mute

This block applies a separate gain to each channel of a stereo stream of 24-bit two's-complement samples. One sample pair arrives per frame strobe. Each channel's gain comes from a 16-bit unsigned control word on a linear scale where 16384 means unity. Values below 16384 attenuate the sample. Values above 16384 boost it, and the result saturates.

To avoid audible clicks, the gain actually applied never jumps. On each frame strobe it moves a bounded step toward its target. The target is either the control word or zero, whichever muting selects. A hardware mute pin acts on both channels. Software mute bits act on each channel separately.

A zero detector watches both inputs. It raises a flag once both channels have carried zero for a long unbroken run of frames. It drops the flag in the frame where any nonzero sample appears.

Top module: `stereo_atten`

## Requirements
- R1: After reset, both applied gains equal unity (16384). Both outputs read 0, and `valid_o` and `zero_o` are low.
- R2: In the cycle after a strobe, each channel's output equals floor(sample * g / 16384), where g is the gain applied before that strobe's ramp step.
- R3: A scaled result above 8388607 is output as 8388607. A result below -8388608 is output as -8388608.
- R4: On each strobe, the applied gain moves toward its target by GAIN_STEP. It lands exactly on the target when the remaining distance is GAIN_STEP or less.
- R5: Without a strobe, the applied gains and the outputs hold their values.
- R6: While `mute_i` is high, both targets are zero, so both gains ramp down to silence. Once `mute_i` falls, the gains ramp back to their programmed words.
- R7: `soft_mute_i[0]` mutes the left channel and `soft_mute_i[1]` mutes the right channel, each by ramping to zero. The other channel is not affected.
- R8: `zero_o` goes high after the strobe that completes ZERO_RUN+1 consecutive frames in which both samples are zero. It then stays high while such frames continue.
- R9: A strobe that carries a nonzero sample on either channel clears the zero run, and `zero_o` is low in the next cycle.
- R10: `valid_o` is high for exactly the one cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame strobe: one sample pair |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| gain_l_i | input | 16 | Left gain word, 16384 = unity |
| gain_r_i | input | 16 | Right gain word, 16384 = unity |
| soft_mute_i | input | 2 | Per-channel mute, bit 0 left, bit 1 right |
| mute_i | input | 1 | Hardware mute for both channels, active high |
| valid_o | output | 1 | Output pair valid |
| left_o | output | 24 | Scaled left sample |
| right_o | output | 24 | Scaled right sample |
| zero_o | output | 1 | Long zero run on both inputs |

## Verification
The bench builds the block with GAIN_STEP = 64 and ZERO_RUN = 16 rather than the defaults of 1 and 1024. With these values, a ramp from unity to the full 16-bit word takes only a few hundred frames, so the saturated boost region is reached quickly. Mute-down and release ramps also complete many times within one run. The short zero run makes the exact frame where the flag rises, and the frame where it clears, cheap to hit repeatedly. The intermediate ramp values and the landing steps that fall short of a full step remain visible at the outputs.

// File: rtl/stereo_atten_pkg.sv
package stereo_atten_pkg;
  localparam int unsigned CH_L = 0;
  localparam int unsigned CH_R = 1;
  localparam int unsigned N_CH = 2;

  // one bounded move of cur toward tgt
  function automatic int unsigned step_toward(int unsigned cur, int unsigned tgt,
                                              int unsigned step);
    if (tgt > cur) return (tgt - cur <= step) ? tgt : cur + step;
    if (cur > tgt) return (cur - tgt <= step) ? tgt : cur - step;
    return cur;
  endfunction
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 14,
  parameter int unsigned GAIN_STEP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << GAIN_FRAC);

  logic [GAIN_W-1:0] gain_q, gain_d;

  always_comb
    gain_d = GAIN_W'(stereo_atten_pkg::step_toward(32'(gain_q), 32'(target_i),
                                                   32'(GAIN_STEP)));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        gain_q <= UNITY;
    else if (step_en_i) gain_q <= gain_d;

  assign gain_o = gain_q;
endmodule

// File: rtl/gain_scale.sv
module gain_scale #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 14
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [DATA_W-1:0] scaled_o
);
  localparam int unsigned PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] prod, shr;

  always_comb begin
    prod = PW'(sample_i) * $signed({1'b0, gain_i});
    shr  = prod >>> GAIN_FRAC;  // floor
    if (shr > MAXV)      scaled_o = MAXV[DATA_W-1:0];
    else if (shr < MINV) scaled_o = MINV[DATA_W-1:0];
    else                 scaled_o = shr[DATA_W-1:0];
  end
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
  parameter int unsigned ZERO_RUN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic all_zero_i,
  output logic zero_o
);
  localparam int unsigned CW   = $clog2(ZERO_RUN + 2);
  localparam logic [CW-1:0] LIM = CW'(ZERO_RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) begin
      if (!all_zero_i)      cnt_q <= '0;
      else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
    end

  assign zero_o = (cnt_q == LIM);
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 14,
  parameter int unsigned GAIN_STEP = 1,
  parameter int unsigned ZERO_RUN  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [GAIN_W-1:0] gain_l_i,
  input  logic [GAIN_W-1:0] gain_r_i,
  input  logic [1:0]        soft_mute_i,
  input  logic              mute_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              zero_o
);
  import stereo_atten_pkg::*;

  logic [DATA_W-1:0] smp   [N_CH];
  logic [GAIN_W-1:0] word  [N_CH];
  logic [GAIN_W-1:0] gain  [N_CH];
  logic [DATA_W-1:0] scl   [N_CH];
  logic [DATA_W-1:0] out_q [N_CH];

  assign smp[CH_L]  = left_i;
  assign smp[CH_R]  = right_i;
  assign word[CH_L] = gain_l_i;
  assign word[CH_R] = gain_r_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [GAIN_W-1:0] tgt;
    assign tgt = (mute_i || soft_mute_i[c]) ? '0 : word[c];

    gain_ramp #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .GAIN_STEP(GAIN_STEP)) u_ramp (
      .clk_i, .rst_ni, .step_en_i(valid_i), .target_i(tgt), .gain_o(gain[c])
    );

    gain_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
      .sample_i(smp[c]), .gain_i(gain[c]), .scaled_o(scl[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)      out_q[c] <= '0;
      else if (valid_i) out_q[c] <= scl[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;

  zero_detect #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk_i, .rst_ni, .valid_i,
    .all_zero_i(left_i == '0 && right_i == '0),
    .zero_o
  );

  assign left_o  = out_q[CH_L];
  assign right_o = out_q[CH_R];
endmodule

// File: rtl/stereo_atten_chk.sv
module stereo_atten_chk #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_STEP = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic              zero_o,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r
);
  p_valid_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_gain_step_l_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (32'(gain_l) <= 32'($past(gain_l)) + GAIN_STEP) &&
                (32'(gain_l) + GAIN_STEP >= 32'($past(gain_l))));
  p_gain_step_r_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (32'(gain_r) <= 32'($past(gain_r)) + GAIN_STEP) &&
                (32'(gain_r) + GAIN_STEP >= 32'($past(gain_r))));

  p_gain_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(gain_l) && $stable(gain_r) && $stable(left_o));

  p_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_l == '0) |=> left_o == '0);

  p_zero_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> $past(valid_i) && $past(left_i) == '0 && $past(right_i) == '0);

  p_zero_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (left_i != '0 || right_i != '0)) |=> !zero_o);
endmodule

bind stereo_atten stereo_atten_chk #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_STEP(GAIN_STEP)
) u_chk (
  .clk_i, .rst_ni, .valid_i, .left_i, .right_i, .valid_o, .left_o, .zero_o,
  .gain_l(gain[0]), .gain_r(gain[1])
);

// File: tb/sim_stereo_atten.sv
module sim_stereo_atten;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24, GW = 16, FRAC = 14, STEP = 64, ZR = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, mute = 1'b0;
  logic [DW-1:0] l_in = '0, r_in = '0;
  logic [GW-1:0] g_l = 16'd16384, g_r = 16'd16384;
  logic [1:0] smute = 2'b00;
  logic vo, zo;
  logic [DW-1:0] lo, ro;

  int checks = 0, errors = 0;
  int unsigned mg_l = 16384, mg_r = 16384, zc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_atten #(.DATA_W(DW), .GAIN_W(GW), .GAIN_FRAC(FRAC), .GAIN_STEP(STEP),
                 .ZERO_RUN(ZR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(l_in), .right_i(r_in),
    .gain_l_i(g_l), .gain_r_i(g_r), .soft_mute_i(smute), .mute_i(mute),
    .valid_o(vo), .left_o(lo), .right_o(ro), .zero_o(zo)
  );

  function automatic logic [DW-1:0] f_scale(logic [DW-1:0] s, int unsigned g);
    longint sl, p, q;
    sl = longint'($signed(s));
    p  = sl * longint'(g);
    q  = p >>> FRAC;
    if (q > 8388607)  q = 8388607;
    if (q < -8388608) q = -8388608;
    return DW'(q);
  endfunction

  function automatic int unsigned f_step(int unsigned cur, int unsigned tgt);
    if (tgt > cur) return (tgt - cur <= STEP) ? tgt : cur + STEP;
    if (cur > tgt) return (cur - tgt <= STEP) ? tgt : cur - STEP;
    return cur;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one frame: drive at negedge, check at the following negedge
  task automatic frame(logic [DW-1:0] l, logic [DW-1:0] r, string tag);
    logic [DW-1:0] el, er;
    el = f_scale(l, mg_l);
    er = f_scale(r, mg_r);
    mg_l = f_step(mg_l, (mute || smute[0]) ? 0 : 32'(g_l));
    mg_r = f_step(mg_r, (mute || smute[1]) ? 0 : 32'(g_r));
    if (l == '0 && r == '0) begin if (zc < ZR + 1) zc++; end
    else zc = 0;
    l_in = l; r_in = r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(tag, "left_o", longint'($signed(lo)), longint'($signed(el)));
    chk(tag, "right_o", longint'($signed(ro)), longint'($signed(er)));
    chk("R10", "valid_o", longint'(vo), 1);
    chk(tag, "zero_o", longint'(zo), longint'(zc > ZR));
  endtask

  task automatic idle(int n);
    logic [DW-1:0] hl, hr;
    hl = lo; hr = ro;
    for (int i = 0; i < n; i++) begin
      l_in = DW'($urandom); r_in = DW'($urandom);
      @(negedge clk);
      chk("R5", "left_o hold", longint'(lo), longint'(hl));
      chk("R5", "right_o hold", longint'(ro), longint'(hr));
      chk("R10", "valid_o idle", longint'(vo), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "left_o", longint'(lo), 0);
    chk("R1", "right_o", longint'(ro), 0);
    chk("R1", "valid_o", longint'(vo), 0);
    chk("R1", "zero_o", longint'(zo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: unity gain right after reset
    frame(24'h123456, 24'hF00001, "R1");
    frame(24'h7FFFFF, 24'h800000, "R2");
    idle(2);

    // R4: ramp down to a new target, with odd landing
    g_l = 16'd10000; g_r = 16'd16000;
    repeat (110) frame(DW'($urandom), DW'($urandom), "R4");
    idle(1);

    // R3: boost to full word, then saturate both polarities
    g_l = 16'hFFFF; g_r = 16'hFFFF;
    repeat (800) frame(DW'($urandom_range(0, 255)), DW'($urandom_range(0, 255)), "R4");
    frame(24'h7FFFFF, 24'h800000, "R3");
    frame(24'h200000, 24'hDFFFFF, "R3");
    frame(24'h1FFFFF, 24'hE00001, "R3");

    // R6: hardware mute ramps both to silence and back
    mute = 1'b1;
    repeat (1100) frame(DW'($urandom), DW'($urandom), "R6");
    chk("R6", "left gain at zero", longint'(mg_l), 0);
    frame(24'h7FFFFF, 24'h800000, "R6");
    mute = 1'b0; g_l = 16'd16384; g_r = 16'd8192;
    repeat (300) frame(DW'($urandom), DW'($urandom), "R6");

    // R7: soft mute left only, right keeps its gain
    smute = 2'b01;
    repeat (300) frame(DW'($urandom), 24'h400000, "R7");
    smute = 2'b10;
    repeat (300) frame(24'h400000, DW'($urandom), "R7");
    smute = 2'b00;
    repeat (300) frame(DW'($urandom), DW'($urandom), "R7");

    // R8 / R9: zero run boundary and clear
    repeat (ZR) frame('0, '0, "R8");
    chk("R8", "flag still low at ZERO_RUN", longint'(zo), 0);
    frame('0, '0, "R8");
    chk("R8", "flag high at ZERO_RUN+1", longint'(zo), 1);
    idle(3);
    chk("R8", "flag held while idle", longint'(zo), 1);
    repeat (5) frame('0, '0, "R8");
    frame('0, 24'h000001, "R9");
    chk("R9", "flag cleared", longint'(zo), 0);
    repeat (ZR) frame('0, '0, "R9");
    frame(24'hFFFFFF, '0, "R9");
    repeat (ZR + 3) frame('0, '0, "R8");

    // random mix with idles, gain and mute changes
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 40) == 0) g_l = GW'($urandom);
      if ($urandom_range(0, 40) == 0) g_r = GW'($urandom);
      if ($urandom_range(0, 60) == 0) mute = ~mute;
      if ($urandom_range(0, 60) == 0) smute = 2'($urandom);
      if ($urandom_range(0, 3) == 0) frame('0, '0, "R8");
      else frame(DW'($urandom), DW'($urandom), "R2");
      if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule